// File: doc/BRIEF.md
# Reference-Pulse Framing Aligner

This block gives a converter or receiver a multiframe counter whose phase is fixed by a shared reference pulse, so that several devices clocked from the same source agree on where every frame and multiframe begins. The reference input is sampled on the rising clock edge. Only a low-to-high change between two consecutive samples counts as an event. An accepted event reloads the counter with a programmed phase offset. The counter consists of a beat counter of `frame_len_i` clocks and a frame counter of `mf_len_i` frames.

Four states govern the block. In `ST_IDLE` it waits for `arm_i`, which moves it to `ST_ARMED`. In `ST_ARMED` the next event reloads the counter and moves it to `ST_LOCKED`. In `ST_LOCKED` an event that lands on the expected phase is filtered. An event at any other phase sets a sticky error and leaves the counter alone. After such an event the block goes to `ST_RESYNC` in continuous mode or back to `ST_IDLE` in one-shot mode. In `ST_RESYNC` the next event reloads the counter and returns the block to `ST_LOCKED`. In marker mode, events never touch the counter, the state or the error. In every mode, a one-cycle marker tags the first valid data sample at or after each event.

Top module: `sysref_align`

## Requirements
- R1: After reset, `aligned_o`, `err_o` and `marker_o` are 0, and both counters are zero, so `frame_stb_o` and `mframe_stb_o` are both 1 in the first cycle after reset is released.
- R2: The counter runs freely. `frame_stb_o` is high for one cycle every `frame_len_i` clocks. `mframe_stb_o` is high for one cycle every `frame_len_i*mf_len_i` clocks, and always together with `frame_stb_o`.
- R3: `sysref_i` is sampled on each rising clock edge, and one event is a 0 then 1 in two consecutive samples. A pulse held high for several cycles is one event and produces no further reloads and no errors.
- R4: On a reload, the beat counter takes `offset_i` and the frame counter takes 0. This happens on the rising edge after the one that first samples `sysref_i` high. With offset d, the next `mframe_stb_o` comes `frame_len_i*mf_len_i - d` cycles after the reload (immediately when d is 0).
- R5: `arm_i` in `ST_IDLE` moves the block to `ST_ARMED`. In `ST_ARMED`, an event with `mode_i` 00 (one-shot) or 01 (continuous) reloads the counter and moves the block to `ST_LOCKED`. `aligned_o` is 1 exactly in `ST_LOCKED`.
- R6: In `ST_LOCKED`, an event is filtered if the counter would reach (offset, frame 0) on the next cycle without a reload. A filtered event causes no reload and no error, and `aligned_o` stays 1.
- R7: In `ST_LOCKED`, an event at any other phase sets `err_o`, clears `aligned_o` and leaves the counter phase unchanged. In mode 01 the block enters `ST_RESYNC`, and the next event there reloads the counter and returns it to `ST_LOCKED`. In mode 00 the block returns to `ST_IDLE`, where events are ignored until the block is armed again.
- R8: With `mode_i[1]` set (marker mode), events never reload the counter, never change the state and never set `err_o`.
- R9: `err_o` stays 1 until reset.
- R10: In every mode, `marker_o` is a one-cycle pulse registered with the first cycle at or after the event cycle in which `sample_vld_i` is 1. With `sample_vld_i` held high, it appears in the cycle after the reload edge of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sysref_i | input | 1 | System reference, synchronous to clk |
| mode_i | input | 2 | 00 one-shot, 01 continuous, 1x marker only |
| arm_i | input | 1 | Arms the aligner while idle |
| sample_vld_i | input | 1 | Data sample valid strobe |
| frame_len_i | input | BEAT_W | Clocks per frame (F, at least 1) |
| mf_len_i | input | FRM_W | Frames per multiframe (K, at least 1) |
| offset_i | input | BEAT_W | Beat value loaded on reload (below F) |
| frame_stb_o | output | 1 | Frame boundary strobe |
| mframe_stb_o | output | 1 | Multiframe boundary strobe |
| aligned_o | output | 1 | Counter locked to the reference |
| err_o | output | 1 | Sticky loss-of-alignment flag |
| marker_o | output | 1 | Tags the sample that carries a reference event |

## Verification
The properties assume that `sysref_i` already meets setup and hold at the clock, that `frame_len_i`, `mf_len_i` and `offset_i` are static while the block is locked, and that `offset_i` is below `frame_len_i`. The stimulus changes every input half a cycle away from the sampling edge. It fixes F=4 and K=2 with offsets 0 and 3, and changes mode only while no reference pulse is in flight. Each reference pulse is placed at a chosen phase relative to the last reload: on the boundary, three beats off, or held for several cycles.

// File: rtl/sysref_align_pkg.sv
package sysref_align_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_CONT    = 2'b01,
        MODE_MARK    = 2'b10,
        MODE_MARK_B  = 2'b11
    } ref_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2,
        ST_RESYNC = 2'd3
    } sync_state_e;

endpackage

// File: rtl/sra_capture.sv
// Samples the reference on the device clock and flags a 0->1 change.
module sra_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    logic smp_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            smp_q  <= ref_i;
            prev_q <= smp_q;
        end
    end

    assign edge_o = smp_q & ~prev_q;
endmodule

// File: rtl/sra_frame_ctr.sv
// Beat and frame counters with a phase reload and a phase comparison.
module sra_frame_ctr #(
    parameter int BEAT_W = 6,
    parameter int FRM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BEAT_W-1:0] frame_len_i,
    input  logic [FRM_W-1:0]  mf_len_i,
    input  logic              load_i,
    input  logic [BEAT_W-1:0] load_beat_i,
    output logic              frame_stb_o,
    output logic              mframe_stb_o,
    output logic              phase_ok_o
);
    logic [BEAT_W-1:0] beat_q, beat_nxt;
    logic [FRM_W-1:0]  frm_q, frm_nxt;
    logic              beat_last, frm_last;

    assign beat_last = beat_q >= (frame_len_i - BEAT_W'(1));
    assign frm_last  = frm_q  >= (mf_len_i - FRM_W'(1));

    always_comb begin
        beat_nxt = beat_last ? '0 : beat_q + BEAT_W'(1);
        frm_nxt  = frm_q;
        if (beat_last) begin
            frm_nxt = frm_last ? '0 : frm_q + FRM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            frm_q  <= '0;
        end else if (load_i) begin
            beat_q <= load_beat_i;
            frm_q  <= '0;
        end else begin
            beat_q <= beat_nxt;
            frm_q  <= frm_nxt;
        end
    end

    // True when a reload would not move the counter.
    assign phase_ok_o   = (beat_nxt == load_beat_i) && (frm_nxt == '0);
    assign frame_stb_o  = (beat_q == '0);
    assign mframe_stb_o = (beat_q == '0) && (frm_q == '0);
endmodule

// File: rtl/sra_sync_fsm.sv
// Arming, lock, filtering and loss handling.
module sra_sync_fsm
    import sysref_align_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  ref_mode_e mode_i,
    input  logic      arm_i,
    input  logic      edge_i,
    input  logic      phase_ok_i,
    output logic      load_o,
    output logic      aligned_o,
    output logic      err_o
);
    sync_state_e st_q, st_nxt;
    logic        mis;
    logic        err_q;
    logic        act_edge;

    assign act_edge = edge_i & ~mode_i[1];

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   if (arm_i) st_nxt = ST_ARMED;
            ST_ARMED:  if (act_edge) st_nxt = ST_LOCKED;
            ST_LOCKED: if (act_edge && !phase_ok_i)
                           st_nxt = (mode_i == MODE_CONT) ? ST_RESYNC : ST_IDLE;
            ST_RESYNC: if (act_edge) st_nxt = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            err_q <= err_q | mis;
        end
    end

    always_comb begin
        load_o = 1'b0;
        mis    = 1'b0;
        unique case (st_q)
            ST_IDLE:   ;
            ST_ARMED:  load_o = act_edge;
            ST_LOCKED: mis    = act_edge & ~phase_ok_i;
            ST_RESYNC: load_o = act_edge;
        endcase
    end

    assign aligned_o = (st_q == ST_LOCKED);
    assign err_o     = err_q;
endmodule

// File: rtl/sra_marker.sv
// Tags the first valid sample at or after a reference event.
module sra_marker (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic vld_i,
    output logic marker_o
);
    logic pend_q;
    logic mark_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            mark_q <= 1'b0;
        end else begin
            pend_q <= (pend_q | edge_i) & ~vld_i;
            mark_q <= vld_i & (pend_q | edge_i);
        end
    end

    assign marker_o = mark_q;
endmodule

// File: rtl/sysref_align.sv
module sysref_align
    import sysref_align_pkg::*;
#(
    parameter int BEAT_W = 6,
    parameter int FRM_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref_i,
    input  logic [1:0]        mode_i,
    input  logic              arm_i,
    input  logic              sample_vld_i,
    input  logic [BEAT_W-1:0] frame_len_i,
    input  logic [FRM_W-1:0]  mf_len_i,
    input  logic [BEAT_W-1:0] offset_i,
    output logic              frame_stb_o,
    output logic              mframe_stb_o,
    output logic              aligned_o,
    output logic              err_o,
    output logic              marker_o
);
    logic edge_w;
    logic load_w;
    logic phase_ok_w;

    sra_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (sysref_i),
        .edge_o (edge_w)
    );

    sra_frame_ctr #(.BEAT_W(BEAT_W), .FRM_W(FRM_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_len_i  (frame_len_i),
        .mf_len_i     (mf_len_i),
        .load_i       (load_w),
        .load_beat_i  (offset_i),
        .frame_stb_o  (frame_stb_o),
        .mframe_stb_o (mframe_stb_o),
        .phase_ok_o   (phase_ok_w)
    );

    sra_sync_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (ref_mode_e'(mode_i)),
        .arm_i      (arm_i),
        .edge_i     (edge_w),
        .phase_ok_i (phase_ok_w),
        .load_o     (load_w),
        .aligned_o  (aligned_o),
        .err_o      (err_o)
    );

    sra_marker u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_w),
        .vld_i    (sample_vld_i),
        .marker_o (marker_o)
    );
endmodule

// File: rtl/sysref_align_chk.sv
module sysref_align_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sysref_i,
    input logic [1:0] mode_i,
    input logic       sample_vld_i,
    input logic       frame_stb_o,
    input logic       mframe_stb_o,
    input logic       aligned_o,
    input logic       err_o,
    input logic       marker_o
);
    // R2
    mf_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_stb_o |-> frame_stb_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R7
    align_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aligned_o) |-> err_o);

    // R4
    lock_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned_o) |-> ($past(sysref_i, 2) && !$past(sysref_i, 3)));

    // R8
    mark_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && aligned_o) |=> aligned_o);

    // R10
    marker_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        marker_o |=> !marker_o);

    // R10
    marker_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        marker_o |-> $past(sample_vld_i));
endmodule

bind sysref_align sysref_align_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sysref_i     (sysref_i),
    .mode_i       (mode_i),
    .sample_vld_i (sample_vld_i),
    .frame_stb_o  (frame_stb_o),
    .mframe_stb_o (mframe_stb_o),
    .aligned_o    (aligned_o),
    .err_o        (err_o),
    .marker_o     (marker_o)
);

// File: tb/sysref_align_bench.sv
module sysref_align_bench;
    localparam int CLK_PERIOD = 10;
    localparam int F  = 4;
    localparam int K  = 2;
    localparam int MF = F * K;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sysref = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       arm = 1'b0;
    logic       vld = 1'b1;
    logic [5:0] offset = '0;
    logic       frame_stb, mframe_stb, aligned, err, marker;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int ph_l = 0;
    int ph_d = 0;
    bit done = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sysref_align u_sysref_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .sysref_i     (sysref),
        .mode_i       (mode),
        .arm_i        (arm),
        .sample_vld_i (vld),
        .frame_len_i  (6'(F)),
        .mf_len_i     (5'(K)),
        .offset_i     (offset),
        .frame_stb_o  (frame_stb),
        .mframe_stb_o (mframe_stb),
        .aligned_o    (aligned),
        .err_o        (err),
        .marker_o     (marker)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one reference pulse; pushes the expected marker cycle (R10).
    task automatic pulse(input int len);
        sysref = 1'b1;
        if (vld) exp_q.push_back(cyc + 2);
        step(len);
        sysref = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1;
        step(1);
        arm = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    // Step until (cyc - ph_l) mod MF equals m.
    task automatic align_to(input int m);
        while (((cyc - ph_l) % MF + MF) % MF != m) step(1);
    endtask

    // R2 / R4: strobes follow the modelled phase.
    task automatic check_phase(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            int pos;
            pos = ((cyc - ph_l + ph_d) % MF + MF) % MF;
            chk(frame_stb == (pos % F == 0), {req, " frame_stb"}, frame_stb, pos % F == 0);
            chk(mframe_stb == (pos == 0), {req, " mframe_stb"}, mframe_stb, pos == 0);
            step(1);
        end
    endtask

    // Monitor: scoreboard for marker pulses (R10).
    always @(negedge clk) begin
        if (rst_n && marker && !done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 unexpected marker", cyc, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(cyc == e, "R10 marker cycle", cyc, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            chk(0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        // R1 reset state
        chk(aligned == 0, "R1 aligned", aligned, 0);
        chk(err == 0, "R1 err", err, 0);
        chk(marker == 0, "R1 marker", marker, 0);
        chk(mframe_stb == 1, "R1 mframe_stb", mframe_stb, 1);
        // R2 free running from reset
        ph_l = 0; ph_d = 0;
        check_phase("R2", 16);

        // R5 one-shot: arm, event locks; R4 reload phase
        mode = 2'b00;
        do_arm();
        while (cyc % MF != 3) step(1);
        ph_l = cyc + 2; ph_d = 0;
        pulse(1);
        step(1);
        chk(aligned == 1, "R5 locked", aligned, 1);
        chk(err == 0, "R5 err", err, 0);
        check_phase("R4", 12);
        // R6 in-phase event filtered
        align_to(6);
        pulse(1);
        step(3);
        chk(aligned == 1, "R6 aligned kept", aligned, 1);
        chk(err == 0, "R6 no err", err, 0);
        check_phase("R6", 8);
        // R7 one-shot loss: err, unlock, no reload
        align_to(1);
        pulse(1);
        step(1);
        chk(err == 1, "R7 err set", err, 1);
        chk(aligned == 0, "R7 aligned clear", aligned, 0);
        check_phase("R7 no reload", 8);
        // R7 idle ignores events until re-armed
        align_to(2);
        pulse(1);
        step(2);
        chk(aligned == 0, "R7 idle ignores", aligned, 0);
        check_phase("R7 idle", 8);
        chk(err == 1, "R9 err sticky", err, 1);

        // R9 reset clears err; R3 long pulse in continuous mode
        do_reset();
        chk(err == 0, "R9 err cleared", err, 0);
        ph_l = 0; ph_d = 0;
        mode = 2'b01;
        do_arm();
        step(2);
        ph_l = cyc + 2;
        pulse(5);
        step(3);
        chk(aligned == 1, "R3 locked by long pulse", aligned, 1);
        chk(err == 0, "R3 one event only", err, 0);
        check_phase("R3", 8);
        for (int i = 0; i < 3; i++) begin
            align_to(6);
            pulse(2);
            step(1);
        end
        chk(err == 0, "R6 periodic no err", err, 0);
        chk(aligned == 1, "R6 periodic aligned", aligned, 1);
        // R7 continuous loss, then resync
        align_to(1);
        pulse(1);
        step(1);
        chk(err == 1, "R7 cont err", err, 1);
        chk(aligned == 0, "R7 cont unlocked", aligned, 0);
        check_phase("R7 cont no reload", 4);
        step(1);
        ph_l = cyc + 2;
        pulse(1);
        step(1);
        chk(aligned == 1, "R7 resync locked", aligned, 1);
        chk(err == 1, "R9 err kept", err, 1);
        check_phase("R7 resync", 8);

        // R4 offset
        do_reset();
        ph_l = 0; ph_d = 0;
        mode = 2'b00;
        offset = 6'd3;
        do_arm();
        while (cyc % MF != 5) step(1);
        ph_l = cyc + 2; ph_d = 3;
        pulse(1);
        step(1);
        chk(mframe_stb == 0, "R4 offset not at boundary", mframe_stb, 0);
        check_phase("R4 offset", 16);
        align_to(6);
        pulse(1);
        step(2);
        chk(err == 0, "R6 offset in phase", err, 0);

        // R8 marker mode: no reload, no err, state kept
        mode = 2'b10;
        align_to(1);
        pulse(1);
        step(2);
        chk(err == 0, "R8 no err", err, 0);
        chk(aligned == 1, "R8 aligned kept", aligned, 1);
        check_phase("R8 no reload", 8);

        // R10 marker waits for a valid sample
        vld = 1'b0;
        pulse(1);
        step(4);
        exp_q.push_back(cyc + 1);
        vld = 1'b1;
        step(3);
        chk(exp_q.size() == 0, "R10 all markers seen", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule